// File: doc/BRIEF.md
# Card-Detect Control Register Block

A small word-addressed register block for a board controller. Two locations return fixed identification and decode values, one location reads as zero, and a status word reports two signals from a memory-card controller.

The write-protect signal shows in the status word as a live copy of its level. A card-inserted pulse is caught in a sticky bit that drives an interrupt line. That bit and the interrupt stay high until software writes a one to the bit's position. Both card signals cross into the block's clock domain through a two-flop synchroniser. Reads are combinational from the current address. A write takes effect at the clock edge on which it is presented.

Top module: `card_detect_regs`

## Requirements
- R1: Word address 0 reads 0x41034003, word address 3 reads 0x00000011 and word address 1 reads 0x00000000.
- R2: Status word (address 2) bit 0 equals the write-protect input level after two clock edges of synchronisation. A level set up before edge k is visible after edge k+1 and not after edge k. All status bits other than 0 and 3 read zero.
- R3: When the synchronised card-inserted input is high, status bit 3 and irq_o are high after the next edge, that is three edges after the raw input rises. A low input never clears them.
- R4: A write to address 2 whose data has bit 3 set clears status bit 3 and irq_o at that edge. A write to address 2 with data bit 3 clear leaves bit 3 unchanged. No write changes status bit 0.
- R5: A clear takes priority over a card-inserted input that is still high. Bit 3 reads zero for one cycle and is set again at the following edge.
- R6: Writes to addresses 0, 1, 3 and to addresses 4 and above change nothing. Addresses 4 and above read zero.
- R7: Asserting rst_ni low clears the status word and irq_o at once.
- R8: irq_o always equals status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W (4) | Word address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i, combinational |
| wp_i | input | 1 | Write-protect level from card controller |
| cardin_i | input | 1 | Card-inserted indication from card controller |
| irq_o | output | 1 | Card-insert interrupt, high while the latch is set |

## Verification
The write-protect input is toggled with reads taken one and two edges after the change. This separates a correct two-stage synchroniser from a missing or extra stage.

The card input is tried in three forms:
- A short pulse that is then dropped, to tell a sticky latch from a mirror.
- A clear while the input is low.
- A clear while the input is still high, to tell clear priority from set priority.

All-ones writes go to every non-status address and to the status word with bit 3 clear. These show that only the one decoded bit can clear the latch and that the write-protect bit cannot be written.

// File: rtl/cdreg_pkg.sv
package cdreg_pkg;
  localparam int unsigned WORD_ID    = 0;
  localparam int unsigned WORD_FLASH = 1;
  localparam int unsigned WORD_STAT  = 2;
  localparam int unsigned WORD_DEC   = 3;
  localparam int unsigned NUM_IN     = 2;
  localparam int unsigned IN_WP      = 0;
  localparam int unsigned IN_CARD    = 1;
endpackage

// File: rtl/cdreg_sync.sv
module cdreg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cdreg_status.sv
module cdreg_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wp_s_i,
  input  logic card_s_i,
  input  logic clr_i,
  output logic wp_o,
  output logic card_o
);
  logic card_q;

  // clear wins; a still-high input re-sets on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      card_q <= 1'b0;
    else if (clr_i)   card_q <= 1'b0;
    else if (card_s_i) card_q <= 1'b1;
  end

  assign wp_o   = wp_s_i;
  assign card_o = card_q;

  // R3
  card_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_s_i && !clr_i) |=> card_q);
  // R3
  card_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_q && !clr_i) |=> card_q);
  // R4
  card_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !card_q);
endmodule

// File: rtl/cdreg_decode.sv
module cdreg_decode
  import cdreg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       CARD_BIT  = 3,
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DEC_VALUE = 32'h0000_0011
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clr_o
);
  localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(1) << CARD_BIT;

  logic hit_stat;
  assign hit_stat = (addr_i == ADDR_W'(WORD_STAT));

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(WORD_ID))       rdata_o = ID_VALUE;
    else if (addr_i == ADDR_W'(WORD_DEC)) rdata_o = DEC_VALUE;
    else if (hit_stat)                    rdata_o = status_i;
  end

  assign clr_o = sel_i && we_i && hit_stat && (|(wdata_i & CLR_MASK));
endmodule

// File: rtl/card_detect_regs.sv
module card_detect_regs
  import cdreg_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 4,
  parameter int unsigned       DATA_W      = 32,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       WP_BIT      = 0,
  parameter int unsigned       CARD_BIT    = 3,
  parameter logic [DATA_W-1:0] ID_VALUE    = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DEC_VALUE   = 32'h0000_0011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wp_i,
  input  logic              cardin_i,
  output logic              irq_o
);
  logic [NUM_IN-1:0] raw_in, sync_in;
  logic              wp_live, card_lat, clr;
  logic [DATA_W-1:0] status;

  assign raw_in[IN_WP]   = wp_i;
  assign raw_in[IN_CARD] = cardin_i;

  cdreg_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_in)
  );

  cdreg_status i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wp_s_i   (sync_in[IN_WP]),
    .card_s_i (sync_in[IN_CARD]),
    .clr_i    (clr),
    .wp_o     (wp_live),
    .card_o   (card_lat)
  );

  always_comb begin
    status           = '0;
    status[WP_BIT]   = wp_live;
    status[CARD_BIT] = card_lat;
  end

  cdreg_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CARD_BIT(CARD_BIT),
    .ID_VALUE(ID_VALUE), .DEC_VALUE(DEC_VALUE)
  ) i_decode (
    .sel_i    (sel_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status),
    .rdata_o  (rdata_o),
    .clr_o    (clr)
  );

  assign irq_o = card_lat;

  // R1
  id_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(WORD_ID)) |-> (rdata_o == ID_VALUE));
  // R8
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(WORD_STAT)) |-> (rdata_o[CARD_BIT] == irq_o));
  // R6
  other_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i != ADDR_W'(WORD_STAT) && !sync_in[IN_CARD])
      |=> (irq_o == $past(irq_o)));
  // R2
  stat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(WORD_STAT)) |->
      ((rdata_o & ~((DATA_W'(1) << WP_BIT) | (DATA_W'(1) << CARD_BIT))) == '0));
endmodule

// File: tb/test_card_detect_regs.sv
module test_card_detect_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wp_i = 1'b0, cardin_i = 1'b0, irq_o;

  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  card_detect_regs i_card_detect_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .wp_i(wp_i), .cardin_i(cardin_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  // status holds 0x8 (card latched, wp low) while the table runs
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0,  32'h0,        32'h4103_4003},  // R1
    '{1'b0, 4'd1,  32'h0,        32'h0},          // R1
    '{1'b0, 4'd3,  32'h0,        32'h0000_0011},  // R1
    '{1'b0, 4'd4,  32'h0,        32'h0},          // R6
    '{1'b0, 4'd9,  32'h0,        32'h0},          // R6
    '{1'b0, 4'd15, 32'h0,        32'h0},          // R6
    '{1'b1, 4'd0,  32'hFFFF_FFFF, 32'h8},         // R6
    '{1'b1, 4'd1,  32'hFFFF_FFFF, 32'h8},         // R6
    '{1'b1, 4'd3,  32'hFFFF_FFFF, 32'h8},         // R6
    '{1'b1, 4'd5,  32'hFFFF_FFFF, 32'h8},         // R6
    '{1'b1, 4'd15, 32'hFFFF_FFFF, 32'h8},         // R6
    '{1'b0, 4'd1,  32'h0,        32'h0},          // R6
    '{1'b0, 4'd3,  32'h0,        32'h0000_0011},  // R6
    '{1'b0, 4'd2,  32'h0,        32'h8}           // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    step(1);
    sel_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    step(3);
    rd(4'd2, d); check("R7 reset status", d, 32'h0);
    check("R7 reset irq", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    step(1);

    // R2 write-protect mirror latency
    wp_i = 1'b1;
    step(1); rd(4'd2, d); check("R2 wp after one edge", d, 32'h0);
    step(1); rd(4'd2, d); check("R2 wp after two edges", d, 32'h1);
    wp_i = 1'b0;
    step(2); rd(4'd2, d); check("R2 wp low", d, 32'h0);

    // R3 card pulse latched
    cardin_i = 1'b1;
    step(2); check("R3 irq not yet", {31'b0, irq_o}, 32'h0);
    step(1); check("R3 irq set", {31'b0, irq_o}, 32'h1);
    cardin_i = 1'b0;
    step(4); rd(4'd2, d); check("R3 sticky after input low", d, 32'h8);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        wr(VEC[i].addr, VEC[i].wdata);
        rd(4'd2, d);
        check("R6 write ignored", d, VEC[i].exp);
      end else begin
        rd(VEC[i].addr, d);
        check("R1/R6 read", d, VEC[i].exp);
      end
    end

    // R4 clear behaviour
    wr(4'd2, 32'hFFFF_FFF7);
    check("R4 no clear without bit 3", {31'b0, irq_o}, 32'h1);
    wr(4'd2, 32'h0000_0008);
    rd(4'd2, d); check("R4 cleared", d, 32'h0);
    check("R8 irq low after clear", {31'b0, irq_o}, 32'h0);
    wp_i = 1'b1;
    step(2);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, d); check("R4 wp bit not writable", d, 32'h1);
    wp_i = 1'b0;
    step(2);

    // R5 clear while input still high
    cardin_i = 1'b1;
    step(3); check("R5 set before clear", {31'b0, irq_o}, 32'h1);
    wr(4'd2, 32'h8);
    check("R5 cleared one cycle", {31'b0, irq_o}, 32'h0);
    step(1); check("R5 re-set next edge", {31'b0, irq_o}, 32'h1);
    cardin_i = 1'b0;
    step(3);

    // R7 asynchronous reset mid-run
    rst_ni = 1'b0;
    rd(4'd2, d); check("R7 async reset status", d, 32'h0);
    check("R7 async reset irq", {31'b0, irq_o}, 32'h0);
    step(1);
    rst_ni = 1'b1;
    step(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule